// File: doc/BRIEF.md
# Halfword Access Splitting Sequencer

This block sits between a host port that issues 8-, 16- and 32-bit accesses (plus a four-word read burst) and an external memory bus whose data path is only 16 bits wide. Each accepted host request becomes an ordered series of halfword beats. Each beat runs until the external side raises a ready input. Read halfwords are packed back into host words in little-endian order, and the host receives one response per 32-bit word.

The region mode bits are sampled when a request is accepted. One bit selects synchronous or asynchronous signalling. The other bit marks the region as multiplexed: in that case every beat is preceded by a one-cycle address phase in which the low address bits travel on the shared data lines. Writes always run as asynchronous beats. Request combinations that the bus cannot carry are answered at once with an error response, and no beat is issued for them.

Top module: `hws_split_seq`

## Requirements
- R1: After reset `bus_req_o`, `bus_ale_o` and `rsp_valid_o` are low and `req_ready_o` is high.
- R2: A non-burst request with size code 0 (8-bit) or 1 (16-bit) runs one beat at the request address with bit 0 cleared. Lanes `bus_be_o` are 2'b01 for an 8-bit access at an even address, 2'b10 for one at an odd address, and 2'b11 for a 16-bit access. On writes the lanes are further ANDed with `req_be_i[1:0]` when address bit 1 is 0, or with `req_be_i[3:2]` when it is 1.
- R3: A non-burst request with size code 2 (32-bit) runs two beats at the word-aligned address and then at that address plus 2, with lanes 2'b11 (ANDed with `req_be_i[1:0]`, then `[3:2]`, on writes). On writes, `req_wdata_i[15:0]` goes out on the first beat and `[31:16]` on the second.
- R4: Read responses are lane-aligned. A 32-bit word is {second halfword, first halfword}. A 16-bit read places its halfword in the upper lane when address bit 1 is 1 and in the lower lane otherwise. An 8-bit read places its byte at byte lane `addr[1:0]`; that byte is the upper byte of the beat for odd addresses and the lower byte otherwise. All other bits are zero, and write responses carry zero data.
- R5: A burst read (`req_burst_i`=1, size ignored) in synchronous mode runs eight beats at the word-aligned address plus 2k (k=0..7) with `bus_burst_o` high. It returns four responses in ascending address order, each {beat 2j+1, beat 2j}.
- R6: A burst with `req_write_i`=1, a burst with `mode_sync_i`=0, or a non-burst request with size code 3 produces no beat. The response is `rsp_valid_o`=1 with `rsp_err_o`=1, one cycle after acceptance.
- R7: Write beats drive `bus_sync_o` low. Read beats drive `bus_sync_o` equal to the `mode_sync_i` value sampled at acceptance.
- R8: With `mode_mux_i`=1 each beat is preceded by exactly one cycle with `bus_ale_o`=1 and `bus_dout_o` equal to `bus_addr_o[15:0]`. With `mode_mux_i`=0 no address phase occurs.
- R9: While a data beat waits for `bus_ready_i`, the beat address, lanes, write flag and data stay unchanged.
- R10: `rsp_valid_o` pulses in the cycle after the clock edge at which the last beat of a word sees `bus_ready_i` high. `req_ready_o` is low while any beat or address phase is in progress.
- R11: Successive beats of one request step the bus address by exactly 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request present |
| req_ready_o | output | 1 | Sequencer idle, request accepted this cycle |
| req_addr_i | input | AW | Host byte address |
| req_size_i | input | 2 | 0: 8-bit, 1: 16-bit, 2: 32-bit, 3: invalid |
| req_write_i | input | 1 | Write request |
| req_burst_i | input | 1 | Four-word burst read |
| req_wdata_i | input | 32 | Lane-aligned write data |
| req_be_i | input | 4 | Host byte enables |
| mode_sync_i | input | 1 | Region uses synchronous signalling |
| mode_mux_i | input | 1 | Region shares address and data lines |
| bus_req_o | output | 1 | Beat or address phase active |
| bus_ale_o | output | 1 | Address phase on shared lines |
| bus_we_o | output | 1 | Write data phase |
| bus_sync_o | output | 1 | Beat uses synchronous signalling |
| bus_burst_o | output | 1 | Beat belongs to a burst |
| bus_addr_o | output | AW | Halfword-aligned beat address |
| bus_be_o | output | 2 | Active byte lanes of the beat |
| bus_dout_o | output | 16 | Address (address phase) or write data |
| bus_din_i | input | 16 | Read data from the device |
| bus_ready_i | input | 1 | Ends the current data phase |
| rsp_valid_o | output | 1 | Host response pulse |
| rsp_err_o | output | 1 | Request rejected |
| rsp_rdata_o | output | 32 | Packed read data |

## Verification
Requests of every size are issued at all four byte offsets, reads and writes, with random partial byte enables and with multiplexed and plain regions. This shows whether lane selection, halfword order and the address phase are tied to the right address bits and to the right region bit. The device returns a halfword computed from the address, so a swapped or shifted halfword produces a wrong packed word. Ready is held high in some runs and randomly withheld in others, which separates beats that wait correctly from beats that complete early. Directed bursts check the eight-step ordering. Each of the three rejected combinations is issued on its own to confirm that each one is caught individually.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } state_e;

  // active lanes of a halfword beat from size and low address bit
  function automatic logic [1:0] beat_lanes(logic [1:0] size, logic wide, logic a0);
    if (!wide && size == SZ_BYTE) return a0 ? 2'b10 : 2'b01;
    return 2'b11;
  endfunction
endpackage

// File: rtl/hws_decode.sv
module hws_decode
  import hws_pkg::*;
#(
  parameter int AW          = 24,
  parameter int BURST_BEATS = 8,
  parameter int CW          = 3
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          write_i,
  input  logic          burst_i,
  input  logic          sync_i,
  output logic          err_o,
  output logic          wide_o,
  output logic [AW-1:0] base_o,
  output logic [1:0]    off_o,
  output logic [CW-1:0] last_o
);
  always_comb begin
    wide_o = burst_i || (size_i == SZ_WORD);
    base_o = wide_o ? {addr_i[AW-1:2], 2'b00} : {addr_i[AW-1:1], 1'b0};
    off_o  = addr_i[1:0];
    if (burst_i)                last_o = CW'(BURST_BEATS - 1);
    else if (size_i == SZ_WORD) last_o = CW'(1);
    else                        last_o = '0;
    // bursts are sync reads only; size code 3 has no meaning
    err_o = burst_i ? (write_i || !sync_i) : (size_i == SZ_RSVD);
  end
endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
#(
  parameter int AW = 24,
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic          req_burst_i,
  input  logic [31:0]   req_wdata_i,
  input  logic [3:0]    req_be_i,
  input  logic          mode_sync_i,
  input  logic          mode_mux_i,
  input  logic          dec_err_i,
  input  logic          dec_wide_i,
  input  logic [AW-1:0] dec_base_i,
  input  logic [1:0]    dec_off_i,
  input  logic [CW-1:0] dec_last_i,
  input  logic          bus_ready_i,
  output logic          req_ready_o,
  output logic          bus_req_o,
  output logic          bus_ale_o,
  output logic          bus_we_o,
  output logic          bus_sync_o,
  output logic          bus_burst_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_be_o,
  output logic [15:0]   bus_dout_o,
  output logic          beat_done_o,
  output logic          word_done_o,
  output logic          acc_err_o,
  output logic          hsel_o,
  output logic          wide_o,
  output logic          wr_o,
  output logic [1:0]    size_o,
  output logic [1:0]    off_o
);
  state_e        state_q;
  logic [CW-1:0] beat_q, last_q;
  logic [AW-1:0] base_q, cur_addr;
  logic          wide_q, wr_q, burst_q, sync_q, mux_q;
  logic [1:0]    size_q, off_q;
  logic [31:0]   wdata_q;
  logic [3:0]    be_q;
  logic          accept, hsel;
  logic [1:0]    lanes;
  logic [15:0]   wr_half;

  assign accept = req_valid_i && (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      last_q  <= '0;
      base_q  <= '0;
      wide_q  <= 1'b0;
      wr_q    <= 1'b0;
      burst_q <= 1'b0;
      sync_q  <= 1'b0;
      mux_q   <= 1'b0;
      size_q  <= '0;
      off_q   <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept && !dec_err_i) begin
            state_q <= mode_mux_i ? ST_ADDR : ST_DATA;
            beat_q  <= '0;
            last_q  <= dec_last_i;
            base_q  <= dec_base_i;
            wide_q  <= dec_wide_i;
            wr_q    <= req_write_i;
            burst_q <= req_burst_i;
            sync_q  <= mode_sync_i;
            mux_q   <= mode_mux_i;
            size_q  <= req_size_i;
            off_q   <= dec_off_i;
            wdata_q <= req_wdata_i;
            be_q    <= req_be_i;
          end
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          if (bus_ready_i) begin
            if (beat_q == last_q) begin
              state_q <= ST_IDLE;
            end else begin
              beat_q  <= beat_q + 1'b1;
              state_q <= mux_q ? ST_ADDR : ST_DATA;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // halfword within the host word served by this beat
  assign hsel     = wide_q ? beat_q[0] : off_q[1];
  assign cur_addr = base_q + (AW'(beat_q) << 1);
  assign wr_half  = hsel ? wdata_q[31:16] : wdata_q[15:0];

  always_comb begin
    lanes = beat_lanes(size_q, wide_q, off_q[0]);
    if (wr_q) lanes = lanes & (hsel ? be_q[3:2] : be_q[1:0]);
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign bus_req_o   = (state_q != ST_IDLE);
  assign bus_ale_o   = (state_q == ST_ADDR);
  assign bus_we_o    = (state_q == ST_DATA) && wr_q;
  assign bus_sync_o  = bus_req_o && sync_q && !wr_q;
  assign bus_burst_o = bus_req_o && burst_q;
  assign bus_addr_o  = bus_req_o ? cur_addr : '0;
  assign bus_be_o    = bus_req_o ? lanes : 2'b00;

  always_comb begin
    bus_dout_o = 16'h0000;
    if (state_q == ST_ADDR) bus_dout_o = cur_addr[15:0];
    else if (bus_we_o)      bus_dout_o = wr_half;
  end

  assign beat_done_o = (state_q == ST_DATA) && bus_ready_i;
  assign word_done_o = beat_done_o && (!wide_q || beat_q[0]);
  assign acc_err_o   = accept && dec_err_i;
  assign hsel_o      = hsel;
  assign wide_o      = wide_q;
  assign wr_o        = wr_q;
  assign size_o      = size_q;
  assign off_o       = off_q;
endmodule

// File: rtl/hws_pack.sv
module hws_pack
  import hws_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        beat_done_i,
  input  logic        word_done_i,
  input  logic        acc_err_i,
  input  logic        hsel_i,
  input  logic        wide_i,
  input  logic        wr_i,
  input  logic [1:0]  size_i,
  input  logic [1:0]  off_i,
  input  logic [15:0] din_i,
  output logic        rsp_valid_o,
  output logic        rsp_err_o,
  output logic [31:0] rsp_rdata_o
);
  logic [15:0] lo_q;
  logic [7:0]  byte_sel;
  logic [31:0] word_nx;

  assign byte_sel = off_i[0] ? din_i[15:8] : din_i[7:0];

  always_comb begin
    if (wr_i)                  word_nx = 32'h0;
    else if (wide_i)           word_nx = {din_i, lo_q};
    else if (size_i == SZ_HALF) word_nx = off_i[1] ? {din_i, 16'h0} : {16'h0, din_i};
    else                       word_nx = {24'h0, byte_sel} << {off_i, 3'b000};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q        <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      if (beat_done_i && !hsel_i) lo_q <= din_i;
      rsp_valid_o <= word_done_i || acc_err_i;
      rsp_err_o   <= acc_err_i;
      if (word_done_i)    rsp_rdata_o <= word_nx;
      else if (acc_err_i) rsp_rdata_o <= 32'h0;
    end
  end
endmodule

// File: rtl/hws_split_seq.sv
module hws_split_seq
  import hws_pkg::*;
#(
  parameter int AW          = 24,
  parameter int BURST_WORDS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [1:0]    req_size_i,
  input  logic          req_write_i,
  input  logic          req_burst_i,
  input  logic [31:0]   req_wdata_i,
  input  logic [3:0]    req_be_i,
  input  logic          mode_sync_i,
  input  logic          mode_mux_i,
  output logic          bus_req_o,
  output logic          bus_ale_o,
  output logic          bus_we_o,
  output logic          bus_sync_o,
  output logic          bus_burst_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_be_o,
  output logic [15:0]   bus_dout_o,
  input  logic [15:0]   bus_din_i,
  input  logic          bus_ready_i,
  output logic          rsp_valid_o,
  output logic          rsp_err_o,
  output logic [31:0]   rsp_rdata_o
);
  localparam int BURST_BEATS = 2 * BURST_WORDS;
  localparam int CW          = $clog2(BURST_BEATS);

  logic          dec_err, dec_wide;
  logic [AW-1:0] dec_base;
  logic [1:0]    dec_off;
  logic [CW-1:0] dec_last;
  logic          beat_done, word_done, acc_err, hsel, wide, wr;
  logic [1:0]    size_q, off_q;

  hws_decode #(.AW(AW), .BURST_BEATS(BURST_BEATS), .CW(CW)) u_decode (
    .addr_i (req_addr_i),
    .size_i (req_size_i),
    .write_i(req_write_i),
    .burst_i(req_burst_i),
    .sync_i (mode_sync_i),
    .err_o  (dec_err),
    .wide_o (dec_wide),
    .base_o (dec_base),
    .off_o  (dec_off),
    .last_o (dec_last)
  );

  hws_ctrl #(.AW(AW), .CW(CW)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_size_i (req_size_i),
    .req_write_i(req_write_i),
    .req_burst_i(req_burst_i),
    .req_wdata_i(req_wdata_i),
    .req_be_i   (req_be_i),
    .mode_sync_i(mode_sync_i),
    .mode_mux_i (mode_mux_i),
    .dec_err_i  (dec_err),
    .dec_wide_i (dec_wide),
    .dec_base_i (dec_base),
    .dec_off_i  (dec_off),
    .dec_last_i (dec_last),
    .bus_ready_i(bus_ready_i),
    .req_ready_o(req_ready_o),
    .bus_req_o  (bus_req_o),
    .bus_ale_o  (bus_ale_o),
    .bus_we_o   (bus_we_o),
    .bus_sync_o (bus_sync_o),
    .bus_burst_o(bus_burst_o),
    .bus_addr_o (bus_addr_o),
    .bus_be_o   (bus_be_o),
    .bus_dout_o (bus_dout_o),
    .beat_done_o(beat_done),
    .word_done_o(word_done),
    .acc_err_o  (acc_err),
    .hsel_o     (hsel),
    .wide_o     (wide),
    .wr_o       (wr),
    .size_o     (size_q),
    .off_o      (off_q)
  );

  hws_pack u_pack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .beat_done_i(beat_done),
    .word_done_i(word_done),
    .acc_err_i  (acc_err),
    .hsel_i     (hsel),
    .wide_i     (wide),
    .wr_i       (wr),
    .size_i     (size_q),
    .off_i      (off_q),
    .din_i      (bus_din_i),
    .rsp_valid_o(rsp_valid_o),
    .rsp_err_o  (rsp_err_o),
    .rsp_rdata_o(rsp_rdata_o)
  );
endmodule

// File: rtl/hws_split_seq_chk.sv
module hws_split_seq_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_ready_o,
  input logic          bus_req_o,
  input logic          bus_ale_o,
  input logic          bus_we_o,
  input logic          bus_sync_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_be_o,
  input logic [15:0]   bus_dout_o,
  input logic          bus_ready_i,
  input logic          rsp_valid_o,
  input logic          rsp_err_o
);
  AST_HALF_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !bus_addr_o[0]); // R2

  AST_ERR_NO_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> !bus_req_o); // R6

  AST_WRITE_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> !bus_sync_o); // R7

  AST_ALE_LEADS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> (bus_req_o && !bus_ale_o)); // R8

  AST_ALE_CARRIES_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |-> (bus_dout_o == bus_addr_o[15:0])); // R8

  AST_WAIT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ale_o && !bus_ready_i) |=>
      (bus_req_o && !bus_ale_o && $stable(bus_addr_o) && $stable(bus_be_o) &&
       $stable(bus_dout_o) && $stable(bus_we_o))); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !req_ready_o); // R10

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ale_o && bus_ready_i) |=>
      (!bus_req_o || (bus_addr_o == $past(bus_addr_o) + AW'(2)))); // R11
endmodule

bind hws_split_seq hws_split_seq_chk #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .bus_req_o  (bus_req_o),
  .bus_ale_o  (bus_ale_o),
  .bus_we_o   (bus_we_o),
  .bus_sync_o (bus_sync_o),
  .bus_addr_o (bus_addr_o),
  .bus_be_o   (bus_be_o),
  .bus_dout_o (bus_dout_o),
  .bus_ready_i(bus_ready_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_err_o  (rsp_err_o)
);

// File: tb/hws_split_seq_test.sv
module hws_split_seq_test;
  localparam int AW = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          req_valid, req_write, req_burst, mode_sync, mode_mux;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata;
  logic [3:0]    req_be;
  logic          bus_ready;
  logic [15:0]   bus_din;
  wire           req_ready, bus_req, bus_ale, bus_we, bus_sync, bus_burst;
  wire [AW-1:0]  bus_addr;
  wire [1:0]     bus_be;
  wire [15:0]    bus_dout;
  wire           rsp_valid, rsp_err;
  wire [31:0]    rsp_rdata;

  hws_split_seq #(.AW(AW), .BURST_WORDS(4)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_size_i(req_size), .req_write_i(req_write), .req_burst_i(req_burst),
    .req_wdata_i(req_wdata), .req_be_i(req_be),
    .mode_sync_i(mode_sync), .mode_mux_i(mode_mux),
    .bus_req_o(bus_req), .bus_ale_o(bus_ale), .bus_we_o(bus_we),
    .bus_sync_o(bus_sync), .bus_burst_o(bus_burst), .bus_addr_o(bus_addr),
    .bus_be_o(bus_be), .bus_dout_o(bus_dout), .bus_din_i(bus_din),
    .bus_ready_i(bus_ready),
    .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata)
  );

  function automatic logic [15:0] dev_data(input logic [AW-1:0] a);
    return ((a[15:0] ^ 16'h3C5A) * 16'd40503) + {8'h00, a[23:16]};
  endfunction

  assign bus_din = dev_data(bus_addr);

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  int rdy_mode = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bus monitor
  logic [AW-1:0] b_addr [16];
  logic [1:0]    b_be   [16];
  logic          b_we   [16];
  logic          b_sync [16];
  logic          b_bst  [16];
  logic [15:0]   b_dout [16];
  int            b_cyc  [16];
  logic [31:0]   r_data [8];
  logic          r_err  [8];
  int            r_cyc  [8];
  int nbeat, nale, nrsp, ale_bad, hold_bad, busy_bad;
  bit pw;
  logic [AW-1:0] pa;
  logic [1:0]    pb;
  logic [15:0]   pd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (pw && !(bus_req && !bus_ale && bus_addr == pa && bus_be == pb && bus_dout == pd))
        hold_bad++;
      pw = 0;
      bus_ready = (rdy_mode == 1) ? 1'b1 : (($urandom % 3) != 0);
      if (bus_req && req_ready) busy_bad++;
      if (bus_ale) begin
        nale++;
        if (bus_dout != bus_addr[15:0]) ale_bad++;
      end else if (bus_req) begin
        if (bus_ready) begin
          if (nbeat < 16) begin
            b_addr[nbeat] = bus_addr; b_be[nbeat] = bus_be; b_we[nbeat] = bus_we;
            b_sync[nbeat] = bus_sync; b_bst[nbeat] = bus_burst; b_dout[nbeat] = bus_dout;
            b_cyc[nbeat] = cyc;
          end
          nbeat++;
        end else begin
          pw = 1; pa = bus_addr; pb = bus_be; pd = bus_dout;
        end
      end
      if (rsp_valid) begin
        if (nrsp < 8) begin
          r_data[nrsp] = rsp_rdata; r_err[nrsp] = rsp_err; r_cyc[nrsp] = cyc;
        end
        nrsp++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [AW-1:0] addr, input logic [1:0] size, input logic wr,
                     input logic burst, input logic [31:0] wdata, input logic [3:0] be,
                     input logic sync, input logic mux);
    bit err, wide;
    int nb, nw, acc_cyc, wait_n;
    logic [AW-1:0] base;
    err  = burst ? (wr || !sync) : (size == 2'd3);
    wide = burst || (size == 2'd2);
    nb   = err ? 0 : (burst ? 8 : (size == 2'd2 ? 2 : 1));
    nw   = burst ? 4 : 1;
    base = wide ? {addr[AW-1:2], 2'b00} : {addr[AW-1:1], 1'b0};
    @(negedge clk);
    nbeat = 0; nale = 0; nrsp = 0;
    req_addr = addr; req_size = size; req_write = wr; req_burst = burst;
    req_wdata = wdata; req_be = be; mode_sync = sync; mode_mux = mux;
    req_valid = 1'b1;
    acc_cyc = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = ~wdata; req_be = ~be; mode_sync = ~sync; mode_mux = ~mux;
    wait_n = 0;
    while (nrsp < (err ? 1 : nw) && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    repeat (2) @(negedge clk);
    check(nbeat == nb, "R6 beat count", nbeat, nb);
    if (err) begin
      check(nrsp == 1 && r_err[0] == 1'b1, "R6 error response", {31'h0, r_err[0]}, 1);
      check(r_cyc[0] == acc_cyc + 1, "R6 error timing", r_cyc[0], acc_cyc + 1);
      return;
    end
    check(nale == (mux ? nb : 0), "R8 address phase count", nale, mux ? nb : 0);
    check(nrsp == nw, "R5 response count", nrsp, nw);
    for (int k = 0; k < nb && k < 16; k++) begin
      logic hsel;
      logic [1:0] eb;
      hsel = wide ? k[0] : addr[1];
      eb = (!wide && size == 2'd0) ? (addr[0] ? 2'b10 : 2'b01) : 2'b11;
      if (wr) eb = eb & (hsel ? be[3:2] : be[1:0]);
      check(b_addr[k] == base + AW'(2 * k), "R11 beat address", 32'(b_addr[k]), 32'(base + AW'(2 * k)));
      check(b_be[k] == eb, wide ? "R3 beat lanes" : "R2 beat lanes", 32'(b_be[k]), 32'(eb));
      check(b_sync[k] == (wr ? 1'b0 : sync), "R7 sync flag", 32'(b_sync[k]), 32'(wr ? 1'b0 : sync));
      check(b_bst[k] == burst, "R5 burst flag", 32'(b_bst[k]), 32'(burst));
      check(b_we[k] == wr, "R3 write flag", 32'(b_we[k]), 32'(wr));
      if (wr)
        check(b_dout[k] == (hsel ? wdata[31:16] : wdata[15:0]), "R3 write halfword",
              32'(b_dout[k]), 32'(hsel ? wdata[31:16] : wdata[15:0]));
    end
    for (int j = 0; j < nw; j++) begin
      logic [31:0] ex;
      logic [15:0] d;
      int endb;
      d = dev_data(base);
      if (wr) ex = 32'h0;
      else if (wide) ex = {dev_data(base + AW'(4 * j + 2)), dev_data(base + AW'(4 * j))};
      else if (size == 2'd1) ex = addr[1] ? {d, 16'h0} : {16'h0, d};
      else ex = {24'h0, (addr[0] ? d[15:8] : d[7:0])} << {addr[1:0], 3'b000};
      check(r_data[j] == ex && r_err[j] == 1'b0, burst ? "R5 burst word" : "R4 packed word",
            r_data[j], ex);
      endb = wide ? 2 * j + 1 : 0;
      check(r_cyc[j] == b_cyc[endb] + 1, "R10 response timing", r_cyc[j], b_cyc[endb] + 1);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0;
    req_burst = 1'b0; req_wdata = '0; req_be = '0; mode_sync = 1'b0; mode_mux = 1'b0;
    bus_ready = 1'b0;
    nbeat = 0; nale = 0; nrsp = 0; ale_bad = 0; hold_bad = 0; busy_bad = 0; pw = 0;
    repeat (3) @(negedge clk);
    check(bus_req == 1'b0 && bus_ale == 1'b0 && rsp_valid == 1'b0, "R1 reset outputs",
          {29'h0, bus_req, bus_ale, rsp_valid}, 0);
    check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
    rst_n = 1'b1;
    // directed corners
    rdy_mode = 1;
    for (int o = 0; o < 4; o++) begin
      run(24'h001230 + AW'(o), 2'd0, 1'b0, 1'b0, 32'h0, 4'hF, 1'b0, 1'b0); // R2 R4 byte read
      run(24'h004560 + AW'(o), 2'd0, 1'b1, 1'b0, 32'hA1B2C3D4, 4'hF, 1'b1, 1'b1); // R2 byte write
    end
    run(24'h000100, 2'd1, 1'b0, 1'b0, 32'h0, 4'hF, 1'b1, 1'b0);          // R4 low half
    run(24'h000102, 2'd1, 1'b0, 1'b0, 32'h0, 4'hF, 1'b0, 1'b1);          // R4 high half
    run(24'h00ABC4, 2'd2, 1'b1, 1'b0, 32'h11223344, 4'b0110, 1'b1, 1'b0); // R3 R7 partial write
    run(24'h00ABC6, 2'd2, 1'b0, 1'b0, 32'h0, 4'hF, 1'b1, 1'b1);          // R3 R8 word read
    run(24'h3FFFF4, 2'd0, 1'b0, 1'b1, 32'h0, 4'hF, 1'b1, 1'b0);          // R5 burst
    rdy_mode = 0;
    run(24'h012348, 2'd3, 1'b0, 1'b1, 32'h0, 4'hF, 1'b1, 1'b1);          // R5 R8 R9 burst mux
    run(24'h000200, 2'd2, 1'b1, 1'b1, 32'h0, 4'hF, 1'b1, 1'b0);          // R6 burst write
    run(24'h000200, 2'd2, 1'b0, 1'b1, 32'h0, 4'hF, 1'b0, 1'b0);          // R6 async burst
    run(24'h000200, 2'd3, 1'b0, 1'b0, 32'h0, 4'hF, 1'b1, 1'b1);          // R6 size code 3
    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic bst, wr;
      logic [1:0] sz;
      rdy_mode = int'($urandom % 2);
      bst = (($urandom % 6) == 0);
      wr  = bst ? 1'b0 : 1'($urandom);
      sz  = 2'($urandom % 3);
      run(AW'($urandom), sz, wr, bst, $urandom, 4'($urandom), bst ? 1'b1 : 1'($urandom),
          1'($urandom));
    end
    check(ale_bad == 0, "R8 address on shared lines", ale_bad, 0);
    check(hold_bad == 0, "R9 beat held while waiting", hold_bad, 0);
    check(busy_bad == 0, "R10 ready low while busy", busy_bad, 0);
    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #4_000_000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL R10 watchdog act=running exp=finished");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule